// File: doc/BRIEF.md
# Serial Prefix Code Trie Decoder

This block turns a serial stream of prefix-coded bits back into symbols. It walks a fixed binary decoding tree one bit per clock: each accepted bit picks the 0-branch or the 1-branch of the current node. When the walk lands on a leaf, the block reports that leaf's 3-bit symbol index. The walk then goes straight back to the root, so the next bit starts a new codeword with no gap cycle.

The code has seven symbols. Its leaves sit at depths 2, 3 and 4, so the tree is unbalanced. The walker stores only the six interior nodes; a leaf is never a state.

A strobe marks which cycles carry a bit. A flush input abandons any partial codeword. If a flush cuts a codeword short, the block raises a one-cycle truncation flag. Reset is synchronous and active-low.

Top module: `trie_stream_decoder`

## Requirements
- R1: Holding rst_n low at a clock edge puts the walk at the root and drives sym_valid, truncated and sym_out to 0 after that edge. A codeword that was partly received when reset arrived is discarded.
- R2: The codewords and their sym_out indices are:
  - 00 → 0
  - 010 → 1
  - 011 → 2
  - 10 → 3
  - 110 → 4
  - 1110 → 5
  - 1111 → 6
  
  The first bit received is the leftmost bit of each codeword. sym_out never shows a value above 6 while sym_valid is high.
- R3: sym_valid is high for exactly one cycle: the cycle after the clock edge that accepts the last bit of a codeword. sym_out carries that codeword's index in the same cycle.
- R4: After a leaf, the very next accepted bit starts at the root. The back-to-back stream 101100110010110 yields the indices 3,4,2,0,3,4.
- R5: In a cycle with bit_valid low and flush low, the tree position does not change, bit_in is ignored, and no sym_valid pulse follows.
- R6: In a cycle with flush high, the walk returns to the root. truncated is high for exactly the next cycle if the walk was below the root when flush was sampled, and stays low otherwise.
- R7: When flush and bit_valid are both high in the same cycle, flush wins: the bit is discarded and no sym_valid pulse follows.
- R8: sym_valid is never high in two consecutive cycles, because the shortest codeword is two bits long.
- R9: Between pulses, sym_out holds the last emitted index, including across flushes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_in | input | 1 | Serial code bit |
| bit_valid | input | 1 | bit_in carries a bit this cycle |
| flush | input | 1 | Abandon any partial codeword and return to the root |
| sym_out | output | 3 | Index of the last decoded symbol |
| sym_valid | output | 1 | One-cycle pulse when a new symbol is decoded |
| truncated | output | 1 | One-cycle pulse when a flush cut a codeword short |

## Verification
The checker watches several rules on every clock cycle:
- a pulse always traces back to an accepted bit with no flush in the same cycle;
- truncation always traces back to a flush;
- no two pulses come back to back;
- idle and flush cycles produce no pulse;
- sym_out stays within range and holds still between pulses;
- reset clears both flags.

Other behaviour needs the bench's directed scenarios, because it depends on the exact bit history:
- the mapping of each codeword to its index;
- the sample stream decoding to the right sequence;
- a discarded bit leaving no trace in later symbols;
- truncation appearing only for a partial walk.

// File: rtl/trie_pkg.sv
// Package trie_pkg
// Shared types for the serial trie decoder: the interior node encoding,
// the symbol index width and the one-bit tree step function.
// Assumes the fixed seven-leaf code; leaves are never stored as state.
package trie_pkg;

    localparam int SYM_W  = 3;
    localparam int NODE_W = 3;

    // Interior nodes only, named by the path taken from the root
    typedef enum logic [NODE_W-1:0] {
        ND_ROOT = 3'd0,
        ND_0    = 3'd1,
        ND_1    = 3'd2,
        ND_01   = 3'd3,
        ND_11   = 3'd4,
        ND_111  = 3'd5
    } node_e;

    typedef struct packed {
        node_e            nxt;
        logic             leaf;
        logic [SYM_W-1:0] sym;
    } step_t;

    // One step of the walk: the node reached from cur by bit b
    function automatic step_t trie_step(node_e cur, logic b);
        step_t s;
        s.nxt  = ND_ROOT;
        s.leaf = 1'b0;
        s.sym  = '0;
        case (cur)
            ND_ROOT: s.nxt = b ? ND_1 : ND_0;
            ND_0: begin
                if (b) begin
                    s.nxt = ND_01;
                end else begin
                    s.leaf = 1'b1;
                    s.sym  = SYM_W'(0);
                end
            end
            ND_01: begin
                s.leaf = 1'b1;
                s.sym  = b ? SYM_W'(2) : SYM_W'(1);
            end
            ND_1: begin
                if (b) begin
                    s.nxt = ND_11;
                end else begin
                    s.leaf = 1'b1;
                    s.sym  = SYM_W'(3);
                end
            end
            ND_11: begin
                if (b) begin
                    s.nxt = ND_111;
                end else begin
                    s.leaf = 1'b1;
                    s.sym  = SYM_W'(4);
                end
            end
            ND_111: begin
                s.leaf = 1'b1;
                s.sym  = b ? SYM_W'(6) : SYM_W'(5);
            end
            default: s.nxt = ND_ROOT;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/trie_node_walker.sv
// Module trie_node_walker
// Holds the current interior node of the decoding tree and advances it one
// accepted bit at a time. Reports a combinational leaf hit with its symbol.
// Assumes flush has priority over bit_valid; the walk resets to the root
// on a leaf, on flush and on synchronous active-low reset.
module trie_node_walker
    import trie_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_in,
    input  logic             bit_valid,
    input  logic             flush,
    output logic             leaf_hit,
    output logic [SYM_W-1:0] leaf_sym,
    output logic             partial
);

    node_e node_q;
    step_t step;
    logic  accept;

    // Next-node lookup and acceptance qualifier
    always_comb begin
        accept   = bit_valid && !flush;
        step     = trie_step(node_q, bit_in);
        leaf_hit = accept && step.leaf;
        leaf_sym = step.sym;
        partial  = (node_q != ND_ROOT);
    end

    // Tree position register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            node_q <= ND_ROOT;
        end else if (flush) begin
            node_q <= ND_ROOT;
        end else if (accept) begin
            node_q <= step.nxt;
        end
    end

endmodule

// File: rtl/trie_symbol_emitter.sv
// Module trie_symbol_emitter
// Registers the decoder outputs: a one-cycle symbol pulse, a held symbol
// index and a one-cycle truncation flag.
// Assumes leaf_hit is already qualified by acceptance and flush priority.
module trie_symbol_emitter
    import trie_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             leaf_hit,
    input  logic [SYM_W-1:0] leaf_sym,
    input  logic             flush,
    input  logic             partial,
    output logic             sym_valid,
    output logic [SYM_W-1:0] sym_out,
    output logic             truncated
);

    // Output registers; sym_out holds between pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sym_valid <= 1'b0;
            sym_out   <= '0;
            truncated <= 1'b0;
        end else begin
            sym_valid <= leaf_hit;
            truncated <= flush && partial;
            if (leaf_hit) begin
                sym_out <= leaf_sym;
            end
        end
    end

endmodule

// File: rtl/trie_stream_decoder.sv
// Module trie_stream_decoder
// Top of the serial prefix-code decoder: a tree walker feeding a registered
// output stage. One bit per clock at most; results appear one cycle after
// the last bit of a codeword. Synchronous active-low reset.
module trie_stream_decoder
    import trie_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_in,
    input  logic             bit_valid,
    input  logic             flush,
    output logic [SYM_W-1:0] sym_out,
    output logic             sym_valid,
    output logic             truncated
);

    logic             leaf_hit;
    logic [SYM_W-1:0] leaf_sym;
    logic             partial;

    trie_node_walker u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_in    (bit_in),
        .bit_valid (bit_valid),
        .flush     (flush),
        .leaf_hit  (leaf_hit),
        .leaf_sym  (leaf_sym),
        .partial   (partial)
    );

    trie_symbol_emitter u_emit (
        .clk       (clk),
        .rst_n     (rst_n),
        .leaf_hit  (leaf_hit),
        .leaf_sym  (leaf_sym),
        .flush     (flush),
        .partial   (partial),
        .sym_valid (sym_valid),
        .sym_out   (sym_out),
        .truncated (truncated)
    );

endmodule

// File: rtl/trie_decoder_checker.sv
// Module trie_decoder_checker
// Port-level temporal checks for trie_stream_decoder, bound to every
// instance of the top module.
module trie_decoder_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_valid,
    input logic       flush,
    input logic [2:0] sym_out,
    input logic       sym_valid,
    input logic       truncated
);

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!sym_valid && !truncated));

    p_sym_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid |-> (sym_out <= 3'd6));

    p_pulse_from_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid |-> $past(bit_valid && !flush));

    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_valid && !flush) |=> !sym_valid);

    p_trunc_from_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
        truncated |-> $past(flush));

    p_trunc_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        truncated |=> !truncated);

    p_flush_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !sym_valid);

    p_no_back_to_back_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid |=> !sym_valid);

    p_sym_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!sym_valid && $past(rst_n)) |-> $stable(sym_out));

endmodule

bind trie_stream_decoder trie_decoder_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_valid (bit_valid),
    .flush     (flush),
    .sym_out   (sym_out),
    .sym_valid (sym_valid),
    .truncated (truncated)
);

// File: tb/sim_trie_stream_decoder.sv
// Directed bench for trie_stream_decoder, one task per scenario.
module sim_trie_stream_decoder;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_in = 1'b0;
    logic       bit_valid = 1'b0;
    logic       flush = 1'b0;
    logic [2:0] sym_out;
    logic       sym_valid;
    logic       truncated;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    int b2b_seen = 0;
    logic prev_sv = 1'b0;
    logic [2:0] got_q[$];

    always #4 clk = ~clk;

    trie_stream_decoder u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_in    (bit_in),
        .bit_valid (bit_valid),
        .flush     (flush),
        .sym_out   (sym_out),
        .sym_valid (sym_valid),
        .truncated (truncated)
    );

    // Output monitor, sampled on the falling edge
    always @(negedge clk) begin
        cycles <= cycles + 1;
        if (rst_n && sym_valid) got_q.push_back(sym_out);
        if (rst_n && sym_valid && prev_sv) b2b_seen <= b2b_seen + 1;
        prev_sv <= rst_n && sym_valid;
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic b, input logic v, input logic f);
        @(negedge clk);
        bit_in = b;
        bit_valid = v;
        flush = f;
    endtask

    task automatic send_bits(input logic [15:0] bits, input int n);
        for (int i = n - 1; i >= 0; i--) drive(bits[i], 1'b1, 1'b0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 1'b0);
    endtask

    task automatic expect_seq(input string req, input logic [2:0] exp[$]);
        check(got_q.size() == exp.size(), req, got_q.size(), exp.size());
        if (got_q.size() == exp.size())
            foreach (exp[i]) check(got_q[i] == exp[i], req, got_q[i], exp[i]);
        got_q.delete();
    endtask

    // R1: reset state, and reset discarding a partial codeword
    task automatic t_reset();
        idle(3);
        check(sym_valid == 1'b0, "R1 sym_valid", sym_valid, 0);
        check(truncated == 1'b0, "R1 truncated", truncated, 0);
        check(sym_out == 3'd0, "R1 sym_out", sym_out, 0);
        rst_n = 1'b1;
        send_bits(16'b11, 2);
        drive(1'b0, 1'b0, 1'b0);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        got_q.delete();
        send_bits(16'b00, 2);
        idle(2);
        expect_seq("R1 partial discarded", '{3'd0});
    endtask

    // R2 and R3: each codeword alone, with pulse timing
    task automatic t_table();
        logic [15:0] cw[7] = '{16'b00, 16'b010, 16'b011, 16'b10, 16'b110, 16'b1110, 16'b1111};
        int          ln[7] = '{2, 3, 3, 2, 3, 4, 4};
        for (int s = 0; s < 7; s++) begin
            got_q.delete();
            send_bits(cw[s], ln[s]);
            drive(1'b0, 1'b0, 1'b0);
            check(sym_valid == 1'b1, "R3 pulse after last bit", sym_valid, 1);
            check(sym_out == 3'(s), "R2 symbol index", sym_out, s);
            drive(1'b0, 1'b0, 1'b0);
            check(sym_valid == 1'b0, "R3 pulse one cycle", sym_valid, 0);
            idle(1);
            expect_seq("R2 one symbol", '{3'(s)});
        end
    endtask

    // R4 and R8: back-to-back streams
    task automatic t_stream();
        got_q.delete();
        send_bits(16'b101100110010110, 15);
        idle(2);
        expect_seq("R4 stream", '{3'd3, 3'd4, 3'd2, 3'd0, 3'd3, 3'd4});
        send_bits(16'b000000, 6);
        idle(2);
        expect_seq("R4 repeated shortest", '{3'd0, 3'd0, 3'd0});
        check(b2b_seen == 0, "R8 no consecutive pulses", b2b_seen, 0);
    endtask

    // R5: gaps with a toggling ignored bit
    task automatic t_gaps();
        got_q.delete();
        send_bits(16'b1, 1);
        drive(1'b0, 1'b0, 1'b0);
        drive(1'b1, 1'b0, 1'b0);
        drive(1'b0, 1'b0, 1'b0);
        send_bits(16'b1, 1);
        drive(1'b0, 1'b0, 1'b0);
        drive(1'b1, 1'b0, 1'b0);
        send_bits(16'b10, 2);
        idle(2);
        expect_seq("R5 gaps hold position", '{3'd5});
    endtask

    // R6 and R9: flush behaviour
    task automatic t_flush();
        send_bits(16'b10, 2);
        idle(2);
        got_q.delete();
        send_bits(16'b111, 3);
        drive(1'b0, 1'b0, 1'b1);
        drive(1'b0, 1'b0, 1'b0);
        check(truncated == 1'b1, "R6 truncated after partial", truncated, 1);
        check(sym_out == 3'd3, "R9 hold across flush", sym_out, 3);
        drive(1'b0, 1'b0, 1'b0);
        check(truncated == 1'b0, "R6 truncated one cycle", truncated, 0);
        drive(1'b0, 1'b0, 1'b1);
        drive(1'b0, 1'b0, 1'b0);
        check(truncated == 1'b0, "R6 no truncation at root", truncated, 0);
        send_bits(16'b00, 2);
        idle(2);
        expect_seq("R6 restart at root", '{3'd0});
    endtask

    // R7: flush and a bit in the same cycle
    task automatic t_flush_bit();
        got_q.delete();
        drive(1'b1, 1'b1, 1'b1);
        drive(1'b0, 1'b0, 1'b0);
        check(truncated == 1'b0, "R7 root flush no truncation", truncated, 0);
        check(sym_valid == 1'b0, "R7 no pulse", sym_valid, 0);
        send_bits(16'b00, 2);
        idle(2);
        send_bits(16'b0, 1);
        drive(1'b0, 1'b1, 1'b1);
        drive(1'b0, 1'b0, 1'b0);
        check(sym_valid == 1'b0, "R7 bit discarded", sym_valid, 0);
        check(truncated == 1'b1, "R7 truncated", truncated, 1);
        send_bits(16'b10, 2);
        idle(2);
        expect_seq("R7 discarded bits", '{3'd0, 3'd3});
    endtask

    initial begin
        t_reset();
        t_table();
        t_stream();
        t_gaps();
        t_flush();
        t_flush_bit();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        #800000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule